// File: doc/BRIEF.md
# Transposable Synaptic Weight Array

This block holds an N by N array of multi-bit synaptic weights and lets a client read or write either a whole row vector or a whole column vector in a single request. Row access serves learning steps driven by a presynaptic event. Column access serves steps driven by a postsynaptic event, and the backward product of a two-layer network. Both directions run at the same rate, so neither learning phase waits on the other.

Inside, weight (i,j) sits diagonally at physical column (i+j) mod N of physical row i. Storage is split into N one-weight-wide chunks, and each chunk gets its own row address. A row request gives every chunk the same row. A column request for index j gives chunk c the row (c-j) mod N. A write vector is rotated right by the request index before it reaches the chunks. Read data is rotated left by the same index, so element k of every vector on the ports is always logical element k.

Requests arrive on a valid/ready channel, and read results leave on a second valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is waiting and `rsp_ready` is low. A pending response holds both its valid flag and its data until it is consumed.

Top module: `tsm_weight_mem`

## Requirements
- R1: A row write at index i, followed by a row read at index i, returns the written vector. Vector element k sits at bits [k*WW +: WW].
- R2: A column write at index j, followed by a column read at index j, returns the written vector. Element k is the weight of row k.
- R3: After row writes, a column read at index j returns, as element k, element j of the vector last written to row k.
- R4: After column writes, a row read at index i returns, as element k, element i of the vector last written to column k.
- R5: An accepted read raises `rsp_valid` on the next clock edge, carrying its data. An accepted write produces no response. `rsp_rdata` changes only on an edge that accepts a read.
- R6: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, and `rsp_valid` and `rsp_rdata` hold their values on the next edge.
- R7: A request presented with `req_valid` low, or while `req_ready` is low, changes no weight and produces no response.
- R8: Once reset is applied, `rsp_valid` is 0 and `req_ready` is 1.
- R9: `req_col` = 0 selects a row and `req_col` = 1 selects a column. Every index from 0 to N-1 is valid, and chunk row addresses wrap modulo N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this edge |
| req_write | input | 1 | 1 = write vector, 0 = read vector |
| req_col | input | 1 | 0 = row vector, 1 = column vector |
| req_index | input | $clog2(N) | Row or column index |
| req_wdata | input | N*WW | Write vector, element k at [k*WW +: WW] |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the result this edge |
| rsp_rdata | output | N*WW | Read vector, element k at [k*WW +: WW] |

## Verification
The bench builds the block with N = 4 and 4-bit weights. This size is small enough that every row index and every column index is written and read in both directions. Every chunk offset, including the wrap from index N-1 back to 0, is therefore covered exhaustively. The random phase toggles `rsp_ready` against a mix of reads and writes. This drives stalls that overlap new requests, which shows that a held response and a refused request behave as required.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  // Access direction carried on req_col.
  typedef enum logic {
    DIR_ROW = 1'b0,
    DIR_COL = 1'b1
  } tsm_dir_e;

endpackage

// File: rtl/tsm_addr_gen.sv
// Per-chunk row address: same row for row access, (c - idx) mod N for column access (R9).
module tsm_addr_gen #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          col_sel,
  input  logic [IW-1:0] idx,
  output logic [N*IW-1:0] row_addr
);
  import tsm_pkg::*;

  for (genvar c = 0; c < N; c++) begin : g_chunk
    localparam logic [IW-1:0] CIDX = IW'(c);
    // Width IW wraps naturally since N is a power of two.
    assign row_addr[c*IW +: IW] = (tsm_dir_e'(col_sel) == DIR_COL) ? (CIDX - idx) : idx;
  end

endmodule

// File: rtl/tsm_rotator.sv
// Logarithmic barrel rotator over N elements of WW bits.
// TO_RIGHT=1: out[(k+amt)%N] = in[k]. TO_RIGHT=0: out[k] = in[(k+amt)%N].
module tsm_rotator #(
  parameter int N        = 4,
  parameter int WW       = 4,
  parameter bit TO_RIGHT = 1'b1,
  parameter int IW       = $clog2(N)
) (
  input  logic [N*WW-1:0] din,
  input  logic [IW-1:0]   amt,
  output logic [N*WW-1:0] dout
);
  localparam int STAGES = IW;

  logic [N*WW-1:0] stage_q [STAGES+1];

  assign stage_q[0] = din;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int STEP = 1 << s;
    for (genvar k = 0; k < N; k++) begin : g_elem
      localparam int SRC = TO_RIGHT ? ((k - STEP + N) % N) : ((k + STEP) % N);
      assign stage_q[s+1][k*WW +: WW] = amt[s] ? stage_q[s][SRC*WW +: WW]
                                               : stage_q[s][k*WW +: WW];
    end
  end

  assign dout = stage_q[STAGES];

endmodule

// File: rtl/tsm_chunk.sv
// One weight-wide storage column, N entries deep, combinational read port.
module tsm_chunk #(
  parameter int N  = 4,
  parameter int WW = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] addr,
  input  logic [WW-1:0] wdata,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] cells [N];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/tsm_weight_mem.sv
module tsm_weight_mem #(
  parameter int N  = 4,
  parameter int WW = 4,
  localparam int IW = $clog2(N),
  localparam int DW = N * WW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_col,
  input  logic [IW-1:0] req_index,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata
);

  logic            take;
  logic            take_rd;
  logic            take_wr;
  logic [N*IW-1:0] chunk_addr;
  logic [DW-1:0]   phys_wdata;
  logic [DW-1:0]   phys_rdata;
  logic [DW-1:0]   logic_rdata;

  // R6/R7: a response stuck at the consumer blocks every new request.
  assign req_ready = !(rsp_valid && !rsp_ready);
  assign take      = req_valid && req_ready;
  assign take_rd   = take && !req_write;
  assign take_wr   = take && req_write;

  tsm_addr_gen #(.N(N), .IW(IW)) u_addr (
    .col_sel  (req_col),
    .idx      (req_index),
    .row_addr (chunk_addr)
  );

  // Logical to diagonal order for writes.
  tsm_rotator #(.N(N), .WW(WW), .TO_RIGHT(1'b1), .IW(IW)) u_rot_wr (
    .din  (req_wdata),
    .amt  (req_index),
    .dout (phys_wdata)
  );

  for (genvar c = 0; c < N; c++) begin : g_chunk
    tsm_chunk #(.N(N), .WW(WW), .IW(IW)) u_chunk (
      .clk   (clk),
      .we    (take_wr),
      .addr  (chunk_addr[c*IW +: IW]),
      .wdata (phys_wdata[c*WW +: WW]),
      .rdata (phys_rdata[c*WW +: WW])
    );
  end

  // Diagonal back to logical order for reads.
  tsm_rotator #(.N(N), .WW(WW), .TO_RIGHT(1'b0), .IW(IW)) u_rot_rd (
    .din  (phys_rdata),
    .amt  (req_index),
    .dout (logic_rdata)
  );

  // R5: one-entry response register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (take_rd) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= logic_rdata;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tsm_weight_mem_chk.sv
module tsm_weight_mem_chk #(
  parameter int N  = 4,
  parameter int WW = 4,
  localparam int IW = $clog2(N),
  localparam int DW = N * WW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_valid,
  input logic          rsp_ready
);

  p_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  p_rdata_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> $stable(rsp_rdata));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && !rsp_valid) |=> !rsp_valid);

  p_wrnoresp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !rsp_valid) |=> !rsp_valid);

  p_reset_r8: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

endmodule

bind tsm_weight_mem tsm_weight_mem_chk #(.N(N), .WW(WW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_rdata (rsp_rdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready)
);

// File: tb/tsm_weight_mem_test.sv
module tsm_weight_mem_test;
  localparam int N      = 4;
  localparam int WW     = 4;
  localparam int IW     = $clog2(N);
  localparam int DW     = N * WW;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_col = 1'b0;
  logic [IW-1:0] req_index = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state
  logic [WW-1:0] refm [N][N];
  bit            ev = 1'b0;
  logic [DW-1:0] ed = '0;
  bit            ed_col = 1'b0;
  bit            last_wr_col = 1'b0;
  bit            rand_ready = 1'b0;
  bit            fixed_ready = 1'b1;

  always #(PERIOD/2) clk = ~clk;

  tsm_weight_mem #(.N(N), .WW(WW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_col(req_col), .req_index(req_index),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  // Behavioural model advanced at each edge from the sampled inputs.
  always @(posedge clk) begin
    if (!rst_n) begin
      ev = 1'b0;
    end else begin
      bit rdy;
      rdy = !(ev && !rsp_ready);
      if (ev && rsp_ready) ev = 1'b0;
      if (req_valid && rdy) begin
        if (req_write) begin
          for (int k = 0; k < N; k++) begin
            if (req_col) refm[k][int'(req_index)] = req_wdata[k*WW +: WW];
            else         refm[int'(req_index)][k] = req_wdata[k*WW +: WW];
          end
          last_wr_col = req_col;
        end else begin
          for (int k = 0; k < N; k++) begin
            if (req_col) ed[k*WW +: WW] = refm[k][int'(req_index)];
            else         ed[k*WW +: WW] = refm[int'(req_index)][k];
          end
          ed_col = req_col;
          ev = 1'b1;
        end
      end
    end
  end

  // Consumer readiness, changed just after each edge.
  always @(posedge clk) begin
    #1;
    rsp_ready = rand_ready ? 1'(($urandom % 2)) : fixed_ready;
  end

  // Per-clock comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rsp_valid !== ev) begin
        fails++;
        $display("FAIL R5: rsp_valid actual %0b expected %0b", rsp_valid, ev);
      end
      checks++;
      if (req_ready !== !(ev && !rsp_ready)) begin
        fails++;
        $display("FAIL R6: req_ready actual %0b expected %0b", req_ready, !(ev && !rsp_ready));
      end
      if (ev) begin
        checks++;
        if (rsp_rdata !== ed) begin
          fails++;
          if (!ed_col && !last_wr_col)
            $display("FAIL R1: rdata actual %h expected %h", rsp_rdata, ed);
          else if (ed_col && last_wr_col)
            $display("FAIL R2: rdata actual %h expected %h", rsp_rdata, ed);
          else if (ed_col)
            $display("FAIL R3: rdata actual %h expected %h", rsp_rdata, ed);
          else
            $display("FAIL R4: rdata actual %h expected %h", rsp_rdata, ed);
        end
      end
    end
  end

  task automatic issue(input bit wr, input bit col, input int idx, input logic [DW-1:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_col   = col;   // R9: 0 row, 1 column
    req_index = IW'(idx);
    req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_wdata = DW'($urandom);
  endtask

  function automatic logic [DW-1:0] rnd_vec();
    logic [DW-1:0] v;
    for (int k = 0; k < N; k++) v[k*WW +: WW] = WW'($urandom);
    return v;
  endfunction

  task automatic finish_up();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R8: valid/ready actual %0b/%0b expected 0/1", rsp_valid, req_ready);
    end
    @(posedge clk); #1;

    // R1, R3: row writes, then row reads and column reads (R9: all indices)
    for (int i = 0; i < N; i++) issue(1'b1, 1'b0, i, rnd_vec());
    for (int i = 0; i < N; i++) issue(1'b0, 1'b0, i, '0);
    for (int j = 0; j < N; j++) issue(1'b0, 1'b1, j, '0);

    // R6, R7: stall a response and present a write that must be refused
    fixed_ready = 1'b0;
    @(posedge clk); #2;
    issue(1'b0, 1'b1, N-1, '0);
    req_valid = 1'b1; req_write = 1'b1; req_col = 1'b0;
    req_index = IW'(1); req_wdata = ~rnd_vec();
    repeat (3) @(posedge clk);
    #1;
    req_valid = 1'b0;
    // R7: request with valid low while ready must also be ignored
    fixed_ready = 1'b1;
    req_write = 1'b1; req_index = IW'(2);
    repeat (3) @(posedge clk);
    #1;
    issue(1'b0, 1'b0, 1, '0);   // R7: row 1 unchanged
    issue(1'b0, 1'b0, 2, '0);   // R7: row 2 unchanged

    // R2, R4: column writes, then column reads and row reads
    for (int j = N-1; j >= 0; j--) issue(1'b1, 1'b1, j, rnd_vec());
    for (int j = 0; j < N; j++) issue(1'b0, 1'b1, j, '0);
    for (int i = 0; i < N; i++) issue(1'b0, 1'b0, i, '0);

    // R5, R6: mixed traffic with a randomly stalling consumer
    rand_ready = 1'b1;
    for (int n = 0; n < 300; n++)
      issue(1'($urandom % 4 == 0), 1'($urandom % 2), int'($urandom % N), rnd_vec());
    rand_ready = 1'b0;
    fixed_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    finish_up();
  end

endmodule